// File: doc/BRIEF.md
# Strap-Configured GPIO Port with Upper Address Muxing

This block controls one 8-pin general-purpose I/O port. Software reaches it through a small register window. A direction register chooses, for each pin, whether the pin drives or listens. A function-select register hands any pin over to a secondary function, which here is the upper byte of an external address bus. The address bits come from a bus controller outside this block. When a pin is handed over, pin i carries address bit 16+i.

The function-select register has no fixed reset value. It takes its value from an external-access strap, sampled on the first clock edge after reset is released. A low strap gives every pin to the address bus, and software can then shrink that to a contiguous low-order mask. A high strap leaves the whole port as GPIO. Pad inputs pass through a two-stage synchronizer before software reads them.

Top module: `gpio_strap_port`

## Requirements
- R1: While `rst_n` is low and until the first clock edge after its release, all direction bits and all output-latch bits are 0, and `pad_oe` is 0x00.
- R2: If `strap_n` is low on the first rising clock edge with `rst_n` high, the function-select register (address 2) reads 0xFF after that edge.
- R3: If `strap_n` is high on that edge, the function-select register reads 0x00 after it.
- R4: For a pin whose function-select bit is 0, `pad_oe` equals its direction bit (1 = output), and `pad_out` equals its output-latch bit.
- R5: For a pin whose function-select bit is 1, `pad_oe` is 1 and `pad_out` equals the matching `ext_addr_hi` bit (pin i carries address bit 16+i), whatever its direction bit.
- R6: Writing a contiguous low mask such as 0x03 to function select routes address bits only to pins 0 and 1. The other pins return to GPIO behaviour.
- R7: Reading the data register (address 0) gives the output-latch bit for pins with direction 1. For pins with direction 0 it gives the pad input delayed by two rising edges.
- R8: After the strap-sampling edge, `strap_n` has no effect. Function select changes only through register writes.
- R9: A write (`reg_wen` high) to address 0 (output latch), 1 (direction) or 2 (function select) takes effect on the next rising edge. `reg_rdata` shows the addressed register in the same cycle, and address 3 reads 0x00.
- R10: A function-select write on the strap-sampling edge overrides the strapped value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_n | input | 1 | External-access strap, low = address bus on port |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 data, 1 direction, 2 function select) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output levels |
| pad_oe | output | 8 | Pad output enables |
| ext_addr_hi | input | 8 | External address bits 23..16 |

## Verification
The hardest case to reach is the single strap-sampling edge. On that edge the strap, reset release and a possible function-select write all meet, and afterwards the strap must lose all influence. The stimulus releases reset three times: once with the strap low, once with it high, and once with a function-select write held on the release edge. Between these, it toggles the strap during normal operation. It also changes the pads one cycle at a time, so that the two-edge synchronizer delay shows up in the data read-back of input pins next to output pins.

// File: rtl/gpio_strap_pkg.sv
package gpio_strap_pkg;
    localparam int REG_AW = 2;

    typedef enum logic [REG_AW-1:0] {
        SEL_DATA = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_FSEL = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [STAGES-1:0][W-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_strap_pkg::*;
#(
    parameter int PIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strap_n,
    input  logic             wen,
    input  reg_sel_e         sel,
    input  logic [PIN_W-1:0] wdata,
    output logic [PIN_W-1:0] out_q,
    output logic [PIN_W-1:0] dir_q,
    output logic [PIN_W-1:0] fsel_q,
    output logic             boot_pending
);
    typedef struct packed {
        logic [PIN_W-1:0] outl;
        logic [PIN_W-1:0] dir;
        logic [PIN_W-1:0] fsel;
        logic             boot;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // strap sampled only on the first edge after reset release
        if (st_q.boot) begin
            st_d.fsel = strap_n ? '0 : '1;
            st_d.boot = 1'b0;
        end
        // register writes come later so they override the strap
        if (wen) begin
            unique case (sel)
                SEL_DATA: st_d.outl = wdata;
                SEL_DIR:  st_d.dir  = wdata;
                SEL_FSEL: st_d.fsel = wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.outl <= '0;
            st_q.dir  <= '0;
            st_q.fsel <= '0;
            st_q.boot <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_q        = st_q.outl;
    assign dir_q        = st_q.dir;
    assign fsel_q       = st_q.fsel;
    assign boot_pending = st_q.boot;
endmodule

// File: rtl/gpio_pinmux.sv
module gpio_pinmux #(
    parameter int PIN_W = 8
) (
    input  logic [PIN_W-1:0] out_q,
    input  logic [PIN_W-1:0] dir_q,
    input  logic [PIN_W-1:0] fsel_q,
    input  logic [PIN_W-1:0] ext_bits,
    input  logic [PIN_W-1:0] pad_sync,
    output logic [PIN_W-1:0] pad_out,
    output logic [PIN_W-1:0] pad_oe,
    output logic [PIN_W-1:0] data_rd
);
    for (genvar i = 0; i < PIN_W; i++) begin : g_pin
        always_comb begin
            if (fsel_q[i]) begin
                pad_oe[i]  = 1'b1;
                pad_out[i] = ext_bits[i];
            end else begin
                pad_oe[i]  = dir_q[i];
                pad_out[i] = out_q[i];
            end
            data_rd[i] = dir_q[i] ? out_q[i] : pad_sync[i];
        end
    end
endmodule

// File: rtl/gpio_strap_port.sv
module gpio_strap_port
    import gpio_strap_pkg::*;
#(
    parameter int PIN_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_n,
    input  logic              reg_wen,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [PIN_W-1:0]  reg_wdata,
    output logic [PIN_W-1:0]  reg_rdata,
    input  logic [PIN_W-1:0]  pad_in,
    output logic [PIN_W-1:0]  pad_out,
    output logic [PIN_W-1:0]  pad_oe,
    input  logic [PIN_W-1:0]  ext_addr_hi
);
    reg_sel_e         sel;
    logic [PIN_W-1:0] out_q, dir_q, fsel_q, pad_sync, data_rd;
    logic             boot_pending;

    assign sel = reg_sel_e'(reg_addr);

    gpio_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pad_sync)
    );

    gpio_regs #(.PIN_W(PIN_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .strap_n      (strap_n),
        .wen          (reg_wen),
        .sel          (sel),
        .wdata        (reg_wdata),
        .out_q        (out_q),
        .dir_q        (dir_q),
        .fsel_q       (fsel_q),
        .boot_pending (boot_pending)
    );

    gpio_pinmux #(.PIN_W(PIN_W)) u_mux (
        .out_q    (out_q),
        .dir_q    (dir_q),
        .fsel_q   (fsel_q),
        .ext_bits (ext_addr_hi),
        .pad_sync (pad_sync),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe),
        .data_rd  (data_rd)
    );

    always_comb begin
        unique case (sel)
            SEL_DATA: reg_rdata = data_rd;
            SEL_DIR:  reg_rdata = dir_q;
            SEL_FSEL: reg_rdata = fsel_q;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_strap_port_chk.sv
module gpio_strap_port_chk #(
    parameter int PIN_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             strap_n,
    input logic             reg_wen,
    input logic [1:0]       reg_addr,
    input logic [PIN_W-1:0] reg_wdata,
    input logic [PIN_W-1:0] pad_out,
    input logic [PIN_W-1:0] pad_oe,
    input logic [PIN_W-1:0] ext_addr_hi,
    input logic [PIN_W-1:0] dir_q,
    input logic [PIN_W-1:0] fsel_q,
    input logic             boot_pending
);
    logic fsel_wr, dir_wr;
    assign fsel_wr = reg_wen && (reg_addr == 2'd2);
    assign dir_wr  = reg_wen && (reg_addr == 2'd1);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> pad_oe == '0);

    // R5
    fsel_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsel_q & ~pad_oe) == '0);

    // R5
    addr_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out ^ ext_addr_hi) & fsel_q) == '0);

    // R4
    gpio_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~fsel_q) == (dir_q & ~fsel_q));

    // R2
    strap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(boot_pending) && !$past(fsel_wr)) |->
        fsel_q == ($past(strap_n) ? {PIN_W{1'b0}} : {PIN_W{1'b1}}));

    // R8
    strap_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!boot_pending && !fsel_wr) |=> $stable(fsel_q));

    // R9
    dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dir_wr |=> dir_q == $past(reg_wdata));
endmodule

bind gpio_strap_port gpio_strap_port_chk #(.PIN_W(PIN_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .strap_n      (strap_n),
    .reg_wen      (reg_wen),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .pad_out      (pad_out),
    .pad_oe       (pad_oe),
    .ext_addr_hi  (ext_addr_hi),
    .dir_q        (dir_q),
    .fsel_q       (fsel_q),
    .boot_pending (boot_pending)
);

// File: tb/gpio_strap_port_tb.sv
`timescale 1ns/1ps
module gpio_strap_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strap_n = 1'b0;
    logic       reg_wen = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [7:0] pad_in = 8'h00;
    logic [7:0] pad_out, pad_oe;
    logic [7:0] ext_addr_hi = 8'h5A;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    gpio_strap_port u_dut (
        .clk(clk), .rst_n(rst_n), .strap_n(strap_n), .reg_wen(reg_wen),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .ext_addr_hi(ext_addr_hi)
    );

    // behavioural reference model
    logic [7:0] m_out = 0, m_dir = 0, m_fsel = 0;
    bit         m_boot = 1'b1;
    logic [7:0] m_pipe[$] = '{8'h00, 8'h00};

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_out = 0; m_dir = 0; m_fsel = 0; m_boot = 1'b1;
            m_pipe = '{8'h00, 8'h00};
        end else begin
            m_pipe.push_back(pad_in);
            void'(m_pipe.pop_front());
            if (m_boot) begin
                m_fsel = strap_n ? 8'h00 : 8'hFF;
                m_boot = 1'b0;
            end
            if (reg_wen) begin
                if (reg_addr == 2'd0) m_out = reg_wdata;
                else if (reg_addr == 2'd1) m_dir = reg_wdata;
                else if (reg_addr == 2'd2) m_fsel = reg_wdata;
            end
        end
    end

    function automatic logic [7:0] exp_rd();
        logic [7:0] r;
        case (reg_addr)
            2'd0: for (int i = 0; i < 8; i++) r[i] = m_dir[i] ? m_out[i] : m_pipe[0][i];
            2'd1: r = m_dir;
            2'd2: r = m_fsel;
            default: r = 8'h00;
        endcase
        return r;
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            logic [7:0] e_oe, e_out;
            e_oe  = m_fsel | m_dir;
            e_out = (m_fsel & ext_addr_hi) | (~m_fsel & m_out);
            check("R4 model pad_oe", pad_oe, e_oe);
            check("R5 model pad_out", pad_out, e_out);
            check("R7/R9 model rdata", reg_rdata, exp_rd());
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(5.0 * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1 reset state, strap low
        reg_addr = 2'd1;
        step(3);
        check("R1 oe in reset", pad_oe, 8'h00);
        check("R1 dir in reset", reg_rdata, 8'h00);
        rst_n = 1'b1;
        reg_addr = 2'd2;
        step(1);
        check("R2 strap low fsel", reg_rdata, 8'hFF);
        check("R5 all pins address", pad_out, ext_addr_hi);
        check("R5 all pins driven", pad_oe, 8'hFF);

        // R6 mask down to two address pins
        reg_wen = 1'b1; reg_wdata = 8'h03;
        step(1);
        reg_wen = 1'b0;
        check("R9 fsel write next edge", reg_rdata, 8'h03);
        check("R6 oe with mask", pad_oe, 8'h03);
        check("R6 pad_out with mask", pad_out, {6'b0, ext_addr_hi[1:0]});

        // R4 / R7 GPIO direction and readback
        reg_wen = 1'b1; reg_addr = 2'd1; reg_wdata = 8'hF0;
        step(1);
        reg_addr = 2'd0; reg_wdata = 8'hA5;
        step(1);
        reg_wen = 1'b0; pad_in = 8'h3C;
        step(3);
        check("R4 oe mixed", pad_oe, 8'hF3);
        check("R7 data readback", reg_rdata, 8'hAC);
        pad_in = 8'hC3;
        step(1);
        check("R7 one edge not yet", reg_rdata, 8'hAC);
        step(1);
        check("R7 two edges", reg_rdata, 8'hA3);

        // R8 strap ignored afterwards
        reg_addr = 2'd2; strap_n = 1'b1;
        step(3);
        check("R8 strap ignored", reg_rdata, 8'h03);
        strap_n = 1'b0;
        step(2);
        check("R8 strap ignored low", reg_rdata, 8'h03);
        reg_addr = 2'd3;
        step(1);
        check("R9 unused addr", reg_rdata, 8'h00);

        // R3 strap high
        rst_n = 1'b0; strap_n = 1'b1; reg_addr = 2'd2;
        step(2);
        check("R1 oe in second reset", pad_oe, 8'h00);
        rst_n = 1'b1;
        step(1);
        check("R3 strap high fsel", reg_rdata, 8'h00);
        check("R3 pins idle", pad_oe, 8'h00);

        // R10 write on strap edge wins
        rst_n = 1'b0; strap_n = 1'b0;
        step(2);
        reg_wen = 1'b1; reg_wdata = 8'h0F;
        rst_n = 1'b1;
        step(1);
        reg_wen = 1'b0;
        check("R10 write beats strap", reg_rdata, 8'h0F);

        // mixed traffic against the model
        for (int k = 0; k < 400; k++) begin
            reg_wen     = ($urandom_range(0, 2) == 0);
            reg_addr    = 2'($urandom_range(0, 3));
            reg_wdata   = 8'($urandom);
            pad_in      = 8'($urandom);
            ext_addr_hi = 8'($urandom);
            strap_n     = 1'($urandom);
            step(1);
        end
        finish_run();
    end
endmodule